// File: doc/BRIEF.md
# Three-Mode Light-Load Switching Governor

This block decides, once per oscillator period, how a current-mode flyback PWM stage should switch. It chooses among three modes: ordinary PWM, where every oscillator tick is passed to the PWM latch; burst, where ticks are blanked so the power switch stays off; and supply holdup, where the regular loop is bypassed and a short pulse of fixed minimum width is forced at a slow, fixed rate. The goal is to keep the controller's own supply from sagging into lockout.

All analog decisions arrive as comparator flags. The feedback flags report whether feedback is at or below the burst-low threshold, at or above the burst-high threshold, and below the lower level that qualifies holdup. The supply flags report whether the supply is at or below the holdup entry level, or at or above the holdup exit level. Each flag is resynchronized through a two-stage flop chain. A mode decision is taken only on a tick, and the new mode governs from the next tick onward, so no PWM period is ever cut short.

Top module: `lightload_mode_governor`

## Requirements
- R1: While reset is held and right after it, `mode` is 00 (PWM), and `pwm_clk`, `blank` and `force_pulse` are all low.
- R2: In PWM mode (`mode` 00), each `osc_tick` cycle appears on `pwm_clk` in the same cycle, and `blank` is low.
- R3: If a tick occurs in PWM mode while the synchronized `fb_below_lo` is 1, `mode` becomes 01 (burst) after that tick. In burst, `blank` is high and later ticks do not reach `pwm_clk`.
- R4: Burst has hysteresis. The mode stays 01 while the synchronized `fb_above_hi` is 0, including when feedback lies between the two thresholds. It returns to 00 on the first tick that sees `fb_above_hi` at 1.
- R5: If a tick occurs while the synchronized `vdd_below_entry` and `fb_below_qual` are both 1, `mode` becomes 10 (holdup) from either PWM or burst, taking priority over burst. If `fb_below_qual` is 0, a low supply does not cause holdup. Code 11 never appears.
- R6: Holdup is held while the supply is between the two levels. On a tick that sees `vdd_above_exit` at 1 or `fb_below_qual` at 0, the mode leaves holdup. It goes to 00 if `fb_above_hi` is 1 and to 01 otherwise.
- R7: In holdup, `pwm_clk` stays low. A forced pulse starts on the first holdup tick and then on every `HOLD_TICKS`-th tick (default 8). Outside holdup, no forced pulse starts.
- R8: Every forced pulse keeps `force_pulse` high for exactly `MIN_ON_CYC` clock cycles (default 3), starting in its tick cycle.
- R9: The mode changes only in the cycle after a tick. Flag changes between ticks leave `mode` unchanged.
- R10: A flag is seen by the mode decision only after two clock edges. A flag that first rises in the tick cycle itself has no effect on that tick's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator period start |
| fb_below_lo | input | 1 | Feedback at or below burst-low threshold (asynchronous) |
| fb_above_hi | input | 1 | Feedback at or above burst-high threshold (asynchronous) |
| fb_below_qual | input | 1 | Feedback below holdup qualifying level (asynchronous) |
| vdd_below_entry | input | 1 | Supply at or below holdup entry level (asynchronous) |
| vdd_above_exit | input | 1 | Supply at or above holdup exit level (asynchronous) |
| pwm_clk | output | 1 | Tick forwarded to the PWM set latch |
| blank | output | 1 | High while regular ticks are suppressed |
| force_pulse | output | 1 | Minimum-width forced on request |
| mode | output | 2 | 00 PWM, 01 burst, 10 holdup |

## Verification
The tests walk the flags through several load patterns. Steady high feedback confirms plain pass-through. Falling feedback confirms the burst entry. Feedback parked between the thresholds distinguishes real hysteresis from a single-threshold compare. A supply sag with and without the qualifying feedback level shows that holdup has priority over burst and also depends on that feedback level. A supply parked inside the holdup band, followed by exits with high and low feedback, checks the target of each exit. A long holdup run counts the spacing and the width of the forced pulses. A flag raised in the same cycle as a tick separates a correctly synchronized design from one that samples the raw inputs.

// File: rtl/llgov_pkg.sv
package llgov_pkg;

    typedef enum logic [1:0] {
        MODE_PWM   = 2'b00,
        MODE_BURST = 2'b01,
        MODE_HOLD  = 2'b10
    } mode_e;

    typedef struct packed {
        logic fb_lo;    // feedback at/below burst-low
        logic fb_hi;    // feedback at/above burst-high
        logic fb_qual;  // feedback low enough to qualify holdup
        logic sup_lo;   // supply at/below holdup entry
        logic sup_ok;   // supply at/above holdup exit
    } cmp_flags_t;

    localparam int FLAG_W = $bits(cmp_flags_t);

    // Mode decision taken on an oscillator tick (R3..R6)
    function automatic mode_e next_mode(mode_e cur, cmp_flags_t f);
        mode_e nm;
        nm = cur;
        unique case (cur)
            MODE_HOLD: begin
                if (f.sup_ok || !f.fb_qual)
                    nm = f.fb_hi ? MODE_PWM : MODE_BURST;
            end
            MODE_BURST: begin
                if (f.sup_lo && f.fb_qual)      nm = MODE_HOLD;
                else if (f.fb_hi)               nm = MODE_PWM;
            end
            default: begin
                if (f.sup_lo && f.fb_qual)      nm = MODE_HOLD;
                else if (f.fb_lo)               nm = MODE_BURST;
            end
        endcase
        return nm;
    endfunction

endpackage

// File: rtl/llgov_sync.sv
module llgov_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++)
                stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/llgov_mode_fsm.sv
module llgov_mode_fsm
    import llgov_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  cmp_flags_t flags_s,
    output mode_e      mode
);
    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_PWM;
        else if (tick)
            mode_q <= next_mode(mode_q, flags_s);
    end

    assign mode = mode_q;

    AST_MODE_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mode_q)); // R9
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        mode_q != 2'b11); // R5
    AST_BURST_EXIT: assert property (@(posedge clk) disable iff (rst)
        (tick && mode_q == MODE_BURST && flags_s.fb_hi && !(flags_s.sup_lo && flags_s.fb_qual))
        |=> mode_q == MODE_PWM); // R4
    AST_HOLD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (tick && mode_q != MODE_HOLD && flags_s.sup_lo && flags_s.fb_qual)
        |=> mode_q == MODE_HOLD); // R5

endmodule

// File: rtl/llgov_holdup_pacer.sv
module llgov_holdup_pacer #(
    parameter int HOLD_TICKS = 8,
    parameter int MIN_ON_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic in_hold,
    output logic force_o
);
    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

    logic [CW-1:0] cnt_q;
    logic          fire;

    // Tick counter runs only inside holdup, restarts on every entry (R7)
    always_ff @(posedge clk) begin
        if (rst || !in_hold)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == CW'(HOLD_TICKS - 1)) ? '0 : cnt_q + 1'b1;
    end

    assign fire = tick && in_hold && (cnt_q == '0);

    // Width stretcher for the minimum on-time (R8)
    generate
        if (MIN_ON_CYC > 1) begin : g_stretch
            localparam int SW = $clog2(MIN_ON_CYC);
            logic [SW-1:0] st_q;

            always_ff @(posedge clk) begin
                if (rst)
                    st_q <= '0;
                else if (fire)
                    st_q <= SW'(MIN_ON_CYC - 1);
                else if (st_q != '0)
                    st_q <= st_q - 1'b1;
            end

            assign force_o = fire || (st_q != '0);

            AST_PULSE_HELD: assert property (@(posedge clk) disable iff (rst)
                fire |=> force_o); // R8
        end else begin : g_single
            assign force_o = fire;
        end
    endgenerate

    AST_FORCE_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(force_o) |-> in_hold); // R7

endmodule

// File: rtl/lightload_mode_governor.sv
module lightload_mode_governor
    import llgov_pkg::*;
#(
    parameter int HOLD_TICKS  = 8,
    parameter int MIN_ON_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       fb_below_lo,
    input  logic       fb_above_hi,
    input  logic       fb_below_qual,
    input  logic       vdd_below_entry,
    input  logic       vdd_above_exit,
    output logic       pwm_clk,
    output logic       blank,
    output logic       force_pulse,
    output logic [1:0] mode
);
    cmp_flags_t flags_raw;
    cmp_flags_t flags_s;
    logic [FLAG_W-1:0] flags_s_vec;
    mode_e      mode_cur;

    assign flags_raw = '{fb_lo:   fb_below_lo,
                         fb_hi:   fb_above_hi,
                         fb_qual: fb_below_qual,
                         sup_lo:  vdd_below_entry,
                         sup_ok:  vdd_above_exit};

    // R10: resynchronize every comparator flag
    llgov_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (flags_raw),
        .q   (flags_s_vec)
    );
    assign flags_s = cmp_flags_t'(flags_s_vec);

    llgov_mode_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (osc_tick),
        .flags_s (flags_s),
        .mode    (mode_cur)
    );

    llgov_holdup_pacer #(.HOLD_TICKS(HOLD_TICKS), .MIN_ON_CYC(MIN_ON_CYC)) i_pacer (
        .clk     (clk),
        .rst     (rst),
        .tick    (osc_tick),
        .in_hold (mode_cur == MODE_HOLD),
        .force_o (force_pulse)
    );

    // R2/R3: regular ticks pass only in PWM mode
    assign pwm_clk = osc_tick && (mode_cur == MODE_PWM);
    assign blank   = (mode_cur != MODE_PWM);
    assign mode    = mode_cur;

    AST_CLK_BLANKED: assert property (@(posedge clk) disable iff (rst)
        blank |-> !pwm_clk); // R3
    AST_NO_CLK_WHILE_FORCED: assert property (@(posedge clk) disable iff (rst)
        force_pulse |-> !pwm_clk); // R7

endmodule

// File: tb/test_lightload_mode_governor.sv
module test_lightload_mode_governor;

    localparam int HOLD_TICKS = 8;
    localparam int MIN_ON_CYC = 3;

    logic clk = 0;
    logic rst = 1;
    logic osc_tick = 0;
    logic fb_lo = 0, fb_hi = 0, fb_q = 0, s_lo = 0, s_ok = 0;
    logic pwm_clk, blank, force_pulse;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_mode = 2'b00;
    int         m_cnt  = 0;
    logic m_lo = 0, m_hi = 0, m_q = 0, m_slo = 0, m_sok = 0;

    logic [4:0] q_exp[$];
    string      q_tag[$];
    int         run_len = 0;

    always #4 clk = ~clk;

    lightload_mode_governor #(.HOLD_TICKS(HOLD_TICKS), .MIN_ON_CYC(MIN_ON_CYC)) i_lightload_mode_governor (
        .clk(clk), .rst(rst), .osc_tick(osc_tick),
        .fb_below_lo(fb_lo), .fb_above_hi(fb_hi), .fb_below_qual(fb_q),
        .vdd_below_entry(s_lo), .vdd_above_exit(s_ok),
        .pwm_clk(pwm_clk), .blank(blank), .force_pulse(force_pulse), .mode(mode)
    );

    function automatic logic [1:0] ref_next(logic [1:0] cur, logic lo, logic hi,
                                            logic q, logic slo, logic sok);
        logic hold_req;
        hold_req = slo & q;
        if (cur == 2'b10) begin
            if (!sok && q) return 2'b10;
            return hi ? 2'b00 : 2'b01;
        end
        if (hold_req) return 2'b10;
        if (cur == 2'b01) return hi ? 2'b00 : 2'b01;
        return lo ? 2'b01 : 2'b00;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_flags(logic lo, logic hi, logic q, logic slo, logic sok);
        @(posedge clk); #1;
        fb_lo = lo; fb_hi = hi; fb_q = q; s_lo = slo; s_ok = sok;
        repeat (4) @(posedge clk);
        m_lo = lo; m_hi = hi; m_q = q; m_slo = slo; m_sok = sok;
    endtask

    // driver: raise one tick, push the expected outputs of that tick cycle
    task automatic do_tick(string tag);
        logic exp_force;
        @(posedge clk); #1;
        osc_tick = 1;
        exp_force = 0;
        if (m_mode == 2'b10) begin
            exp_force = (m_cnt == 0);
            m_cnt = (m_cnt + 1) % HOLD_TICKS;
        end else begin
            m_cnt = 0;
        end
        q_exp.push_back({m_mode, (m_mode == 2'b00), (m_mode != 2'b00), exp_force});
        q_tag.push_back(tag);
        m_mode = ref_next(m_mode, m_lo, m_hi, m_q, m_slo, m_sok);
        @(posedge clk); #1;
        osc_tick = 0;
        repeat (5) @(posedge clk);
    endtask

    // monitor: compares tick-cycle outputs and forced pulse widths
    always @(negedge clk) begin
        if (!rst && osc_tick && q_exp.size() > 0) begin
            logic [4:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check({t, " mode"},  mode,        e[4:3]);
            check({t, " pwm"},   pwm_clk,     e[2]);
            check({t, " blank"}, blank,       e[1]);
            check({t, " force"}, force_pulse, e[0]);
        end
        if (!rst && force_pulse) begin
            run_len++;
        end else if (run_len != 0) begin
            check("R8 forced width", run_len, MIN_ON_CYC);
            run_len = 0;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset mode",  mode, 2'b00);
        check("R1 reset blank", blank, 0);
        check("R1 reset force", force_pulse, 0);
        check("R1 reset pwm",   pwm_clk, 0);
        @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        check("R1 after reset mode", mode, 2'b00);

        // R2: nominal load
        set_flags(0, 1, 0, 0, 0);
        repeat (3) do_tick("R2 pwm pass");

        // R9 + R3: feedback falls, no tick yet
        set_flags(1, 0, 0, 0, 0);
        @(negedge clk);
        check("R9 mode held without tick", mode, 2'b00);
        do_tick("R3 entry tick");
        repeat (2) do_tick("R3 burst blank");

        // R4: feedback between thresholds, then above
        set_flags(0, 0, 0, 0, 0);
        repeat (2) do_tick("R4 hysteresis hold");
        set_flags(0, 1, 0, 0, 0);
        do_tick("R4 exit tick");
        do_tick("R4 back in pwm");

        // R5: sag with qualified feedback, straight from PWM
        set_flags(1, 0, 1, 1, 0);
        do_tick("R5 hold entry");
        // R7: pulse spacing across a long holdup run
        repeat (18) do_tick("R7 holdup pacing");

        // R6: supply inside band, then recovered
        set_flags(1, 0, 1, 0, 0);
        repeat (2) do_tick("R6 band hold");
        set_flags(1, 0, 1, 0, 1);
        do_tick("R6 exit to burst");
        do_tick("R6 in burst");

        // R5: unqualified feedback does not enter holdup
        set_flags(1, 0, 0, 1, 0);
        repeat (2) do_tick("R5 unqualified");
        set_flags(1, 0, 1, 1, 0);
        do_tick("R5 burst to hold");
        do_tick("R7 hold again");
        set_flags(0, 1, 0, 1, 0);
        do_tick("R6 exit to pwm");
        do_tick("R6 in pwm");

        // R10: flag rising in the tick cycle itself is not seen
        set_flags(0, 1, 0, 0, 0);
        @(posedge clk); #1;
        fb_lo = 1; fb_hi = 0;
        osc_tick = 1;
        q_exp.push_back({2'b00, 1'b1, 1'b0, 1'b0});
        q_tag.push_back("R10 same-cycle flag");
        @(posedge clk); #1;
        osc_tick = 0;
        @(negedge clk);
        check("R10 mode unchanged", mode, 2'b00);
        repeat (4) @(posedge clk);
        m_lo = 1; m_hi = 0;
        do_tick("R10 seen later");
        @(negedge clk);
        check("R10 burst after sync", mode, 2'b01);

        repeat (5) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule